// File: doc/BRIEF.md
# T1 In-Band Loopback Code Inserter

This block sits on the serial transmit path of a T1 framer, one bit per clock. Each 193-bit frame is one framing slot, marked by a strobe, followed by 192 payload slots. While a loopback request is held, the block replaces every payload bit with a repeating in-band activation or deactivation pattern. The framing slot always carries the incoming bit unchanged, so framing survives inside the looped stream.

Two request inputs choose the pattern. The activate ("up") pattern is `00001`, sent leftmost bit first and repeated. The deactivate ("down") pattern is `001`. A phase counter steps only on payload slots, so a pattern runs on without a break across frame boundaries. Holding both requests at once is an illegal setting. The block flags it and sends the activate pattern, so the line output stays defined. The output bit and the flag are registered, so each appears one clock after the inputs that produce it.

Top module: `lc_loop_gen`

## Requirements
- R1: While `rst_n` is low, `tx_bit` and `cfg_err` are 0, whatever the other inputs are.
- R2: With neither request set, `tx_bit` equals the `pay_bit` of the previous clock.
- R3: In a cycle with `frm_sync` = 1, `tx_bit` one clock later equals that cycle's `pay_bit`, whatever the requests are.
- R4: With only `loop_up` set, payload slots carry `0,0,0,0,1` repeated, starting from the first `0` on the first payload slot after the request rises.
- R5: With only `loop_dn` set, payload slots carry `0,0,1` repeated, starting from the first `0` on the first payload slot after the request rises.
- R6: A framing slot does not advance the pattern: the payload slot after it carries the pattern bit that comes next after the last payload slot before it.
- R7: `cfg_err` equals 1 exactly one clock after a cycle in which both requests are 1. In such cycles the payload slots follow the activate pattern of R4.
- R8: Once both requests are 0, the very next payload slot carries `pay_bit` again.
- R9: When the selected pattern changes from one code to the other, the new code starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_bit | input | 1 | Incoming serial bit for the current slot |
| frm_sync | input | 1 | 1 when the current slot is the framing slot |
| loop_up | input | 1 | Request for the activate pattern |
| loop_dn | input | 1 | Request for the deactivate pattern |
| tx_bit | output | 1 | Serial bit sent to the line, one clock late |
| cfg_err | output | 1 | Both requests were set in the previous cycle |

## Verification
A phase counter that is off by one shows on `tx_bit` at the next payload slot. The lone `1` in a code then lands a bit early or late, and this is visible within one code length (three or five slots) of the fault. A counter that advances on the framing slot gives the same shift, but only at a frame boundary, so each run in the bench crosses at least one framing slot. A stale record of the selected code shows up as a pattern that fails to restart after a switch. It is caught on the first payload slot after the change.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_CODE_W = 8;
  localparam int LC_PH_W   = $clog2(LC_CODE_W);

  typedef logic [LC_CODE_W-1:0] code_t;
  typedef logic [LC_PH_W-1:0]   phase_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_UP   = 2'd1,
    SEL_DN   = 2'd2
  } sel_e;

  // Bit idx of a code of length len, leftmost bit at idx 0
  function automatic logic code_bit(code_t code, int len, phase_t idx);
    int p;
    p = len - 1 - int'(idx);
    return code[p[LC_PH_W-1:0]];
  endfunction

  // Phase after idx, wrapping at the code length
  function automatic phase_t phase_next(phase_t idx, int len);
    if (int'(idx) >= len - 1) return '0;
    return idx + phase_t'(1);
  endfunction
endpackage

// File: rtl/lc_arbiter.sv
module lc_arbiter
  import lc_pkg::*;
(
  input  logic req_up,
  input  logic req_dn,
  output sel_e sel,
  output logic both
);
  always_comb begin
    both = req_up && req_dn;
    if (req_up)      sel = SEL_UP;
    else if (req_dn) sel = SEL_DN;
    else             sel = SEL_NONE;
  end
endmodule

// File: rtl/lc_phase.sv
module lc_phase
  import lc_pkg::*;
#(
  parameter int UP_LEN = 5,
  parameter int DN_LEN = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  sel_e   sel,
  input  logic   frm,
  output phase_t idx_use,
  output int     len_cur,
  output logic   restart
);
  phase_t phase_q;
  sel_e   sel_q;

  always_comb begin
    restart = (sel != sel_q);
    idx_use = restart ? '0 : phase_q;
    len_cur = (sel == SEL_UP) ? UP_LEN : DN_LEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      sel_q   <= SEL_NONE;
    end else begin
      sel_q <= sel;
      if (sel == SEL_NONE) phase_q <= '0;
      else if (!frm)       phase_q <= phase_next(idx_use, len_cur);
      else                 phase_q <= idx_use;
    end
  end

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_NONE && frm && !restart) |=> (phase_q == $past(phase_q)));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != SEL_NONE) |-> (int'(phase_q) < ((sel_q == SEL_UP) ? UP_LEN : DN_LEN)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && sel != SEL_NONE && !frm) |=> (phase_q == phase_t'(1)));
endmodule

// File: rtl/lc_loop_gen.sv
module lc_loop_gen
  import lc_pkg::*;
#(
  parameter code_t UP_CODE = code_t'(5'b00001),
  parameter int    UP_LEN  = 5,
  parameter code_t DN_CODE = code_t'(3'b001),
  parameter int    DN_LEN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pay_bit,
  input  logic frm_sync,
  input  logic loop_up,
  input  logic loop_dn,
  output logic tx_bit,
  output logic cfg_err
);
  sel_e   sel;
  logic   both;
  phase_t idx_use;
  int     len_cur;
  logic   restart;
  code_t  code_sel;
  logic   cbit;
  logic   nxt_bit;

  lc_arbiter u_arb (
    .req_up (loop_up),
    .req_dn (loop_dn),
    .sel    (sel),
    .both   (both)
  );

  lc_phase #(.UP_LEN(UP_LEN), .DN_LEN(DN_LEN)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .frm     (frm_sync),
    .idx_use (idx_use),
    .len_cur (len_cur),
    .restart (restart)
  );

  always_comb begin
    code_sel = (sel == SEL_UP) ? UP_CODE : DN_CODE;
    cbit     = code_bit(code_sel, len_cur, idx_use);
    nxt_bit  = (frm_sync || sel == SEL_NONE) ? pay_bit : cbit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      tx_bit  <= nxt_bit;
      cfg_err <= both;
    end
  end

  // R3
  frame_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(frm_sync)) |-> (tx_bit == $past(pay_bit)));

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(loop_up) && !$past(loop_dn)) |-> (tx_bit == $past(pay_bit)));

  // R7
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cfg_err == ($past(loop_up) && $past(loop_dn))));

  // R1
  reset_chk: assert property (@(posedge clk)
    $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 && !rst_n |-> (!tx_bit && !cfg_err));
endmodule

// File: tb/tb_lc_loop_gen.sv
module tb_lc_loop_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pay_bit = 1'b0, frm_sync = 1'b0, loop_up = 1'b0, loop_dn = 1'b0;
  wire  tx_bit, cfg_err;

  int n_cmp = 0, n_bad = 0;
  int pos = 0, k = 0, prev_sel = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lc_loop_gen dut (
    .clk(clk), .rst_n(rst_n), .pay_bit(pay_bit), .frm_sync(frm_sync),
    .loop_up(loop_up), .loop_dn(loop_dn), .tx_bit(tx_bit), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (slot %0d)", tag, act, exp, pos);
    end
  endtask

  // One bit slot: drive, predict, check one clock later
  task automatic step(input logic up, input logic dn, input string tag);
    logic p, f, e;
    int s;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    p = lfsr[0];
    f = (pos == 0);
    pay_bit = p; frm_sync = f; loop_up = up; loop_dn = dn;
    s = up ? 1 : (dn ? 2 : 0);
    if (s != prev_sel) k = 0;
    prev_sel = s;
    if (f || s == 0) e = p;
    else if (s == 1) begin e = (k % 5 == 4); k++; end
    else begin e = (k % 3 == 2); k++; end
    pos = (pos == 192) ? 0 : pos + 1;
    @(posedge clk); #1;
    chk(f ? "R3" : tag, tx_bit, e);
    chk("R7", cfg_err, up && dn);
  endtask

  task automatic run(input int n, input logic up, input logic dn, input string tag);
    for (int i = 0; i < n; i++) step(up, dn, tag);
  endtask

  task automatic t_reset;
    pay_bit = 1'b1; loop_up = 1'b1; loop_dn = 1'b1; frm_sync = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", tx_bit, 1'b0);
    chk("R1", cfg_err, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    pay_bit = 1'b0; loop_up = 1'b0; loop_dn = 1'b0; frm_sync = 1'b0;
  endtask

  task automatic t_idle;       run(250, 1'b0, 1'b0, "R2"); endtask
  task automatic t_up;         run(420, 1'b1, 1'b0, "R4"); run(3, 1'b0, 1'b0, "R8"); endtask
  task automatic t_frame_cross;
    while (pos != 188) step(1'b0, 1'b0, "R2");
    run(12, 1'b1, 1'b0, "R6");
    run(2, 1'b0, 1'b0, "R8");
    while (pos != 190) step(1'b0, 1'b0, "R2");
    run(8, 1'b0, 1'b1, "R6");
  endtask
  task automatic t_dn;         run(300, 1'b0, 1'b1, "R5"); endtask
  task automatic t_release;    run(20, 1'b0, 1'b0, "R8"); endtask
  task automatic t_both;       run(60, 1'b1, 1'b1, "R7"); run(5, 1'b0, 1'b0, "R8"); endtask
  task automatic t_switch;
    run(7, 1'b1, 1'b0, "R4");
    run(10, 1'b0, 1'b1, "R9");
    run(6, 1'b1, 1'b0, "R9");
    run(4, 1'b1, 1'b1, "R9");
    run(4, 1'b0, 1'b0, "R8");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_idle();
    t_up();
    t_frame_cross();
    t_dn();
    t_release();
    t_both();
    t_switch();
    t_idle();
    finish_up();
  end
endmodule